// File: doc/BRIEF.md
# Multiplier-Free Four-Point FFT

This block transforms four complex fixed-point samples into their four-point discrete Fourier transform. It has two stages of radix-2 butterflies. The only twiddle factor other than one is -j. That factor is applied by exchanging the real and imaginary parts of a value and negating one of them, so the block contains adders and subtractors only and no multiplier.

All four samples are presented in parallel together with a valid strobe. The bins are produced in natural order from a single output register, one clock after the strobe. The output width is two bits wider than the input width, so no bin can overflow. The datapath between the input ports and the output register is purely combinational.

Top module: `fft4_nomul`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and every bit of `out_re` and `out_im` is 0.
- R2: `out_valid` at each rising clock edge takes the value that `in_valid` had just before that edge, so it follows `in_valid` one clock later.
- R3: On a clock edge where `in_valid` is 1, bin 0 becomes x0+x1+x2+x3 and bin 2 becomes x0-x1+x2-x3, for both the real and the imaginary part.
- R4: On a clock edge where `in_valid` is 1, bin 1 becomes (x0-x2) - j(x1-x3). Its real part is (x0.re-x2.re)+(x1.im-x3.im) and its imaginary part is (x0.im-x2.im)-(x1.re-x3.re).
- R5: On a clock edge where `in_valid` is 1, bin 3 becomes (x0-x2) + j(x1-x3). Its real part is (x0.re-x2.re)-(x1.im-x3.im) and its imaginary part is (x0.im-x2.im)+(x1.re-x3.re).
- R6: Every bin is exact, with no wrap, for every input value, including all components at -128 (bin 0 = -512) and all at +127 (bin 0 = +508).
- R7: On a clock edge where `in_valid` is 0, the input data is ignored and `out_re` and `out_im` keep their previous values.
- R8: Sample n occupies bits [n*DW +: DW] of `in_re` and `in_im`, and bin k occupies bits [k*OW +: OW] of `out_re` and `out_im`. All fields are two's complement, with DW=8 and OW=DW+2=10 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The four input samples are valid this cycle |
| in_re | input | 4*DW | Real parts of samples 0..3 |
| in_im | input | 4*DW | Imaginary parts of samples 0..3 |
| out_valid | output | 1 | The bins hold a new result |
| out_re | output | 4*OW | Real parts of bins 0..3 |
| out_im | output | 4*OW | Imaginary parts of bins 0..3 |

## Verification
Each result passes through exactly one register between the input ports and the bins. A vector applied before rising edge N therefore appears on `out_re`, `out_im` and `out_valid` just after edge N. The bench drives inputs on the falling edge and samples the outputs on the following falling edge, half a clock after the capturing edge. For the hold case, the bench drops the strobe, changes the data, and samples after one further edge to confirm that the bins did not move.

// File: rtl/fft4_nomul.sv
module fft4_nomul #(
  parameter int DW = 8,
  parameter int OW = DW + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [4*DW-1:0] in_re,
  input  logic [4*DW-1:0] in_im,
  output logic            out_valid,
  output logic [4*OW-1:0] out_re,
  output logic [4*OW-1:0] out_im
);

  logic signed [DW-1:0] xr [4];
  logic signed [DW-1:0] xi [4];
  logic signed [DW:0]   sr [4];
  logic signed [DW:0]   si [4];
  logic signed [OW-1:0] br [4];
  logic signed [OW-1:0] bi [4];

  for (genvar n = 0; n < 4; n++) begin : g_unpack
    assign xr[n] = in_re[n*DW +: DW];
    assign xi[n] = in_im[n*DW +: DW];
  end

  for (genvar p = 0; p < 2; p++) begin : g_stage1
    assign sr[2*p]   = (DW+1)'(xr[p]) + (DW+1)'(xr[p+2]);
    assign si[2*p]   = (DW+1)'(xi[p]) + (DW+1)'(xi[p+2]);
    assign sr[2*p+1] = (DW+1)'(xr[p]) - (DW+1)'(xr[p+2]);
    assign si[2*p+1] = (DW+1)'(xi[p]) - (DW+1)'(xi[p+2]);
  end

  assign br[0] = OW'(sr[0]) + OW'(sr[2]);
  assign bi[0] = OW'(si[0]) + OW'(si[2]);
  assign br[2] = OW'(sr[0]) - OW'(sr[2]);
  assign bi[2] = OW'(si[0]) - OW'(si[2]);

  assign br[1] = OW'(sr[1]) + OW'(si[3]);
  assign bi[1] = OW'(si[1]) - OW'(sr[3]);
  assign br[3] = OW'(sr[1]) - OW'(si[3]);
  assign bi[3] = OW'(si[1]) + OW'(sr[3]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        for (int k = 0; k < 4; k++) begin
          out_re[k*OW +: OW] <= br[k];
          out_im[k*OW +: OW] <= bi[k];
        end
      end
    end
  end

endmodule

module fft4_nomul_chk #(
  parameter int DW = 8,
  parameter int OW = DW + 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [4*DW-1:0] in_re,
  input logic [4*DW-1:0] in_im,
  input logic            out_valid,
  input logic [4*OW-1:0] out_re,
  input logic [4*OW-1:0] out_im
);

  logic signed [OW-1:0] e0_re, e1_re, e1_im;

  assign e0_re = OW'($signed(in_re[0 +: DW])) + OW'($signed(in_re[DW +: DW]))
               + OW'($signed(in_re[2*DW +: DW])) + OW'($signed(in_re[3*DW +: DW]));
  assign e1_re = OW'($signed(in_re[0 +: DW])) - OW'($signed(in_re[2*DW +: DW]))
               + OW'($signed(in_im[DW +: DW])) - OW'($signed(in_im[3*DW +: DW]));
  assign e1_im = OW'($signed(in_im[0 +: DW])) - OW'($signed(in_im[2*DW +: DW]))
               - OW'($signed(in_re[DW +: DW])) + OW'($signed(in_re[3*DW +: DW]));

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_re) && $stable(out_im)));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ($signed(out_re[0 +: OW]) == $past(e0_re)));

  p_bin1_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ($signed(out_re[OW +: OW]) == $past(e1_re) &&
                  $signed(out_im[OW +: OW]) == $past(e1_im)));

  always_comb begin
    if (!rst_n) begin
      a_reset_r1: assert (out_valid == 1'b0 || $isunknown(out_valid));
    end
  end

endmodule

bind fft4_nomul fft4_nomul_chk #(.DW(DW), .OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
  .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
);

// File: tb/fft4_nomul_bench.sv
module fft4_nomul_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int OW = DW + 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [4*DW-1:0] in_re = '0;
  logic [4*DW-1:0] in_im = '0;
  logic            out_valid;
  logic [4*OW-1:0] out_re;
  logic [4*OW-1:0] out_im;

  int n_checks = 0;
  int n_fails = 0;
  bit done = 1'b0;
  int exp_re [4];
  int exp_im [4];

  fft4_nomul #(.DW(DW), .OW(OW)) u_fft4_nomul (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  function automatic string bin_tag(int k);
    if (k == 1) return "R4";
    if (k == 3) return "R5";
    return "R3";
  endfunction

  task automatic compute(input int r [4], input int i [4]);
    for (int k = 0; k < 4; k++) begin
      exp_re[k] = 0;
      exp_im[k] = 0;
      for (int n = 0; n < 4; n++) begin
        case ((n * k) % 4)
          0: begin exp_re[k] += r[n];  exp_im[k] += i[n];  end
          1: begin exp_re[k] += i[n];  exp_im[k] -= r[n];  end
          2: begin exp_re[k] -= r[n];  exp_im[k] -= i[n];  end
          default: begin exp_re[k] -= i[n]; exp_im[k] += r[n]; end
        endcase
      end
    end
  endtask

  task automatic drive(input int r [4], input int i [4], input logic v);
    for (int n = 0; n < 4; n++) begin
      in_re[n*DW +: DW] = DW'(r[n]);
      in_im[n*DW +: DW] = DW'(i[n]);
    end
    in_valid = v;
  endtask

  task automatic check_bins(input string tag, input logic exp_v);
    int ar, ai;
    bit bad = 0;
    n_checks++;
    if (out_valid !== exp_v) begin
      bad = 1;
      $display("FAIL %s R2 out_valid: actual=%b expected=%b", tag, out_valid, exp_v);
    end
    for (int k = 0; k < 4; k++) begin
      ar = int'($signed(out_re[k*OW +: OW]));
      ai = int'($signed(out_im[k*OW +: OW]));
      if (ar != exp_re[k] || ai != exp_im[k]) begin
        bad = 1;
        $display("FAIL %s %s bin%0d: actual=(%0d,%0d) expected=(%0d,%0d)",
                 tag, bin_tag(k), k, ar, ai, exp_re[k], exp_im[k]);
      end
    end
    if (bad) n_fails++;
  endtask

  task automatic run_vec(input string tag, input int r [4], input int i [4]);
    @(negedge clk);
    drive(r, i, 1'b1);
    compute(r, i);
    @(negedge clk);
    in_valid = 1'b0;
    check_bins(tag, 1'b1);
  endtask

  task automatic t_reset();
    n_checks++;
    if (out_valid !== 1'b0 || out_re !== '0 || out_im !== '0) begin
      n_fails++;
      $display("FAIL R1 reset: actual=%b/%h/%h expected=0/0/0", out_valid, out_re, out_im);
    end
  endtask

  task automatic t_impulse();
    run_vec("R3 impulse", '{5, 0, 0, 0}, '{-3, 0, 0, 0});
    run_vec("R4 shifted impulse", '{0, 7, 0, 0}, '{0, 2, 0, 0});
    run_vec("R5 last impulse", '{0, 0, 0, -9}, '{0, 0, 0, 4});
  endtask

  task automatic t_patterns();
    run_vec("R3 dc", '{10, 10, 10, 10}, '{-2, -2, -2, -2});
    run_vec("R3 alternating", '{20, -20, 20, -20}, '{1, -1, 1, -1});
    run_vec("R4 tone1", '{16, 0, -16, 0}, '{0, -16, 0, 16});
    run_vec("R8 distinct", '{1, 2, 3, 4}, '{5, 6, 7, 8});
  endtask

  task automatic t_corners();
    run_vec("R6 all min", '{-128, -128, -128, -128}, '{-128, -128, -128, -128});
    run_vec("R6 all max", '{127, 127, 127, 127}, '{127, 127, 127, 127});
    run_vec("R6 bin1 extreme", '{127, -128, -128, 127}, '{-128, 127, 127, -128});
    run_vec("R6 bin3 extreme", '{-128, 127, 127, -128}, '{127, -128, -128, 127});
  endtask

  task automatic t_random();
    int r [4];
    int i [4];
    void'($urandom(32'h5eed));
    for (int v = 0; v < 60; v++) begin
      for (int n = 0; n < 4; n++) begin
        r[n] = int'($urandom_range(255)) - 128;
        i[n] = int'($urandom_range(255)) - 128;
      end
      run_vec("R3 random", r, i);
    end
  endtask

  task automatic t_hold();
    run_vec("R7 before hold", '{33, -44, 55, -66}, '{-7, 8, -9, 10});
    @(negedge clk);
    drive('{-100, 90, -80, 70}, '{60, -50, 40, -30}, 1'b0);
    @(negedge clk);
    check_bins("R7 idle data ignored", 1'b0);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    drive('{1, 1, 1, 1}, '{0, 0, 0, 0}, 1'b1);
    @(negedge clk);
    compute('{1, 1, 1, 1}, '{0, 0, 0, 0});
    check_bins("R2 first of pair", 1'b1);
    drive('{0, 3, 0, 0}, '{0, 0, 0, 0}, 1'b1);
    @(negedge clk);
    compute('{0, 3, 0, 0}, '{0, 0, 0, 0});
    in_valid = 1'b0;
    check_bins("R2 second of pair", 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 2 + 1);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_impulse();
    t_patterns();
    t_corners();
    t_random();
    t_hold();
    t_back_to_back();
    @(negedge clk);
    finish_run();
  end

endmodule